// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Controller

This block is the sequencing core of one DMA channel. Software programs a 32-bit control word. Its two low bits select one of four modes: halt, run one buffer then stop, fetch the next descriptor without moving data, or run one buffer then fetch the next descriptor. A transfer request input lets the channel move data. Each accepted beat carries a fixed number of bytes from a remaining-byte counter into a small FIFO modelled only by its occupancy count. A sink-ready input empties that FIFO. When a descriptor must be fetched, the channel raises a request and waits for a valid strobe that carries the next control word.

The sequencer has four states:

- `ST_IDLE` (frozen).
- `ST_RUN` (moving data).
- `ST_DRAIN` (no new data, waiting for the FIFO to empty).
- `ST_FETCH` (waiting for a descriptor).

Transitions:

- `ST_IDLE` goes to `ST_RUN` when the run bit is set. Otherwise it goes to `ST_FETCH` when the link bit is set and a request is present.
- `ST_RUN` goes to `ST_DRAIN` on end of buffer or when software clears the run bit.
- `ST_DRAIN` goes to `ST_FETCH` when the FIFO is empty and link is set. When the FIFO is empty and link is clear, it goes to `ST_IDLE`.
- `ST_FETCH` goes to `ST_RUN` or to `ST_IDLE` on a valid descriptor, depending on the run bit of the new word.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, `ctrl_word`, `bytes_left` and `fifo_lvl` are 0, and `stat_en`, `stat_act` and `desc_req` are low.
- R2: Control word layout: bit 0 is run, bit 1 is link and bits 31:16 are the buffer length in bytes. Bits 15:2 are stored as written and have no effect on sequencing. A write while `stat_act` is low stores the whole word and loads `bytes_left` from bits 31:16.
- R3: With run=0 and link=0, a transfer request moves no data, fetches no descriptor and leaves `stat_act` low.
- R4: In `ST_RUN` with run=1, each cycle that has a request and a FIFO that is not full is a beat. A beat lowers `bytes_left` by STEP (saturating at 0) and raises `fifo_lvl` by 1. The beat that starts with `bytes_left` ≤ STEP gives a one-cycle `eob_pulse`, and bit 0 of `ctrl_word` is cleared by hardware.
- R5: After end of buffer with link=0, `stat_en` and `stat_act` fall once `fifo_lvl` reaches 0, and no descriptor is requested. `stat_en` implies `stat_act`.
- R6: With run=0 and link=1 while frozen, a request raises `desc_req` without any beat. A valid descriptor replaces `ctrl_word`, reloads `bytes_left` and gives a one-cycle `dld_pulse`.
- R7: With run=1 and link=1, end of buffer is followed by the FIFO draining, `stat_en` dropping and `desc_req` rising. A loaded word with run=1 starts a new buffer.
- R8: Clearing run during a transfer stops new beats, but `stat_en` stays high until `fifo_lvl` is 0.
- R9: If link is 1 at or after run is cleared mid-buffer, the rest of the current descriptor is skipped. After the drain, `desc_req` rises with `bytes_left` unchanged.
- R10: A write while `stat_act` is high changes only bits 1:0 of `ctrl_word`.
- R11: Setting run while frozen raises `stat_en` one cycle after the write. A pending request then gives the first beat one cycle later.
- R12: No beat occurs while `fifo_lvl` equals FIFO_DEPTH, and `fifo_lvl` never exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| ctrl_word | output | 32 | Current control word |
| xfer_req | input | 1 | Transfer request |
| sink_rdy | input | 1 | Downstream takes one FIFO entry per cycle |
| desc_req | output | 1 | Descriptor fetch request |
| desc_vld | input | 1 | Descriptor word valid |
| desc_word | input | 32 | Next control word |
| stat_en | output | 1 | Channel enable status |
| stat_act | output | 1 | Channel active status |
| eob_pulse | output | 1 | End-of-buffer event, one cycle |
| dld_pulse | output | 1 | Descriptor-loaded event, one cycle |
| fifo_lvl | output | LVL_W | FIFO occupancy |
| bytes_left | output | 16 | Remaining byte count |

## Verification
The main function is driven in each of the four mode encodings. Halt shows that a request alone does nothing. Run-stop with a stalled sink shows beat counting and FIFO back-pressure apart from the end-of-buffer exit. Load-now shows a fetch that moves no data. Run-link shows the chaining into a running descriptor. Clearing run mid-buffer, with link clear and then with link set, separates a plain drain-and-freeze from a descriptor skip. A busy write with all other fields changed shows that only the two command bits are taken.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int CW_W  = 32;
    localparam int LEN_W = 16;

    typedef struct packed {
        logic [LEN_W-1:0] buf_len;
        logic [7:0]       spare;
        logic             burst_hold;
        logic             ie_dld;
        logic             ie_eob;
        logic             ie_eot;
        logic             eob_arm;
        logic             eot_arm;
        logic             link;
        logic             run;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FETCH = 2'd3
    } chan_state_t;
endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
    import dma_chan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CW_W-1:0] wr_data,
    input  logic            busy,
    input  logic            load_desc,
    input  logic [CW_W-1:0] desc_data,
    input  logic            hw_stop,
    output ctrl_word_t      ctrl,
    output logic            len_load,
    output logic [LEN_W-1:0] len_next
);
    ctrl_word_t nxt;

    always_comb begin
        nxt      = ctrl;
        len_load = 1'b0;
        if (load_desc) begin
            nxt      = ctrl_word_t'(desc_data);
            len_load = 1'b1;
        end else if (wr_en) begin
            if (busy) begin
                // only the command pair may change while the channel is busy
                nxt.run  = wr_data[0];
                nxt.link = wr_data[1];
            end else begin
                nxt      = ctrl_word_t'(wr_data);
                len_load = 1'b1;
            end
        end
        if (hw_stop) nxt.run = 1'b0;
    end

    assign len_next = nxt.buf_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl <= '0;
        else        ctrl <= nxt;
    end
endmodule

// File: rtl/dma_byte_cnt.sv
module dma_byte_cnt #(
    parameter int W    = 16,
    parameter int STEP = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] left,
    output logic         is_zero,
    output logic         is_last
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    assign is_zero = (left == '0);
    assign is_last = (left <= STEP_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    left <= '0;
        else if (load) left <= load_val;
        else if (dec)  left <= is_last ? '0 : left - STEP_V;
    end
endmodule

// File: rtl/dma_fifo_lvl.sv
module dma_fifo_lvl #(
    parameter  int DEPTH = 4,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop_req,
    output logic [LW-1:0] lvl,
    output logic          full,
    output logic          empty
);
    localparam logic [LW-1:0] ONE   = LW'(1);
    localparam logic [LW-1:0] DEP_V = LW'(DEPTH);
    logic pop;

    assign full  = (lvl == DEP_V);
    assign empty = (lvl == '0);
    assign pop   = pop_req && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl <= '0;
        else begin
            unique case ({push, pop})
                2'b10:   lvl <= lvl + ONE;
                2'b01:   lvl <= lvl - ONE;
                default: lvl <= lvl;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic link,
    input  logic xfer_req,
    input  logic cnt_zero,
    input  logic cnt_last,
    input  logic fifo_full,
    input  logic fifo_empty,
    input  logic desc_vld,
    input  logic desc_run,
    output logic beat,
    output logic hw_stop,
    output logic load_desc,
    output logic stat_en,
    output logic stat_act,
    output logic desc_req,
    output logic eob_pulse,
    output logic dld_pulse
);
    chan_state_t st, st_nxt;
    logic        eob_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // events and next state
    always_comb begin
        beat    = (st == ST_RUN) && run && xfer_req && !fifo_full && !cnt_zero;
        eob_evt = (st == ST_RUN) && run && (cnt_zero || (beat && cnt_last));
        st_nxt  = st;
        unique case (st)
            ST_IDLE: begin
                if (run)                   st_nxt = ST_RUN;
                else if (link && xfer_req) st_nxt = ST_FETCH;
            end
            ST_RUN: begin
                if (eob_evt || !run) st_nxt = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (fifo_empty) st_nxt = link ? ST_FETCH : ST_IDLE;
            end
            ST_FETCH: begin
                if (desc_vld) st_nxt = desc_run ? ST_RUN : ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        stat_en   = (st == ST_RUN) || (st == ST_DRAIN);
        stat_act  = (st != ST_IDLE);
        desc_req  = (st == ST_FETCH);
        load_desc = (st == ST_FETCH) && desc_vld;
        dld_pulse = load_desc;
        hw_stop   = eob_evt;
        eob_pulse = eob_evt;
    end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter  int STEP       = 4,
    parameter  int FIFO_DEPTH = 4,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      ctrl_word,
    input  logic             xfer_req,
    input  logic             sink_rdy,
    output logic             desc_req,
    input  logic             desc_vld,
    input  logic [31:0]      desc_word,
    output logic             stat_en,
    output logic             stat_act,
    output logic             eob_pulse,
    output logic             dld_pulse,
    output logic [LVL_W-1:0] fifo_lvl,
    output logic [15:0]      bytes_left
);
    ctrl_word_t       ctrl;
    logic             len_load;
    logic [LEN_W-1:0] len_next;
    logic             beat, hw_stop, load_desc;
    logic             cnt_zero, cnt_last, fifo_full, fifo_empty;

    dma_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .wr_data   (cfg_wdata),
        .busy      (stat_act),
        .load_desc (load_desc),
        .desc_data (desc_word),
        .hw_stop   (hw_stop),
        .ctrl      (ctrl),
        .len_load  (len_load),
        .len_next  (len_next)
    );

    dma_byte_cnt #(.W(LEN_W), .STEP(STEP)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (len_load),
        .load_val (len_next),
        .dec      (beat),
        .left     (bytes_left),
        .is_zero  (cnt_zero),
        .is_last  (cnt_last)
    );

    dma_fifo_lvl #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (beat),
        .pop_req (sink_rdy),
        .lvl     (fifo_lvl),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    dma_chan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl.run),
        .link       (ctrl.link),
        .xfer_req   (xfer_req),
        .cnt_zero   (cnt_zero),
        .cnt_last   (cnt_last),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .desc_vld   (desc_vld),
        .desc_run   (desc_word[0]),
        .beat       (beat),
        .hw_stop    (hw_stop),
        .load_desc  (load_desc),
        .stat_en    (stat_en),
        .stat_act   (stat_act),
        .desc_req   (desc_req),
        .eob_pulse  (eob_pulse),
        .dld_pulse  (dld_pulse)
    );

    assign ctrl_word = ctrl;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
    parameter  int FIFO_DEPTH = 4,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [31:0]      ctrl_word,
    input logic             stat_en,
    input logic             stat_act,
    input logic             eob_pulse,
    input logic             dld_pulse,
    input logic             desc_req,
    input logic             desc_vld,
    input logic [LVL_W-1:0] fifo_lvl,
    input logic [15:0]      bytes_left
);
    // R8
    drain_before_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_en) |-> fifo_lvl == '0);

    // R10
    busy_write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_act && !(desc_req && desc_vld)) |=> $stable(ctrl_word[31:2]));

    // R4
    eob_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eob_pulse |=> !eob_pulse);

    // R4
    eob_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eob_pulse |=> !ctrl_word[0]);

    // R12
    lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_lvl <= LVL_W'(FIFO_DEPTH));

    // R3
    idle_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_en && !dld_pulse && !cfg_wr) |=> (bytes_left == $past(bytes_left)));

    // R3
    idle_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_en |=> fifo_lvl <= $past(fifo_lvl));

    // R6
    dld_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dld_pulse |-> desc_req);

    // R5
    en_implies_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_en |-> stat_act);
endmodule

bind dma_chan_ctrl dma_chan_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (.*);

// File: tb/sim_dma_chan_ctrl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctrl;
    localparam int STEP  = 4;
    localparam int DEPTH = 4;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   ctrl_word;
    logic          xfer_req = 1'b0;
    logic          sink_rdy = 1'b0;
    logic          desc_req;
    logic          desc_vld = 1'b0;
    logic [31:0]   desc_word = '0;
    logic          stat_en, stat_act, eob_pulse, dld_pulse;
    logic [LW-1:0] fifo_lvl;
    logic [15:0]   bytes_left;

    int n_chk = 0, n_err = 0;
    int n_eob = 0, n_dld = 0, n_dreq = 0;
    logic dreq_q = 1'b0;

    always #2 clk = ~clk;

    dma_chan_ctrl #(.STEP(STEP), .FIFO_DEPTH(DEPTH)) u0 (.*);

    always @(negedge clk) begin
        if (eob_pulse) n_eob++;
        if (dld_pulse) n_dld++;
        if (desc_req && !dreq_q) n_dreq++;
        dreq_q <= desc_req;
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] w);
        @(negedge clk);
        cfg_wdata = w;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic give_desc(input logic [31:0] w);
        desc_word = w;
        desc_vld  = 1'b1;
        @(negedge clk);
        desc_vld  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic t_reset;
        chk("R1 ctrl", ctrl_word, 32'h0);
        chk("R1 bytes", 32'(bytes_left), 32'h0);
        chk("R1 lvl", 32'(fifo_lvl), 32'h0);
        chk("R1 flags", {29'h0, stat_en, stat_act, desc_req}, 32'h0);
    endtask

    task automatic t_stop_mode;
        cfg_write(32'h0010_00A8);
        chk("R2 word stored", ctrl_word, 32'h0010_00A8);
        chk("R2 length loaded", 32'(bytes_left), 32'd16);
        xfer_req = 1'b1;
        idle(10);
        chk("R3 no activity", {29'h0, stat_en, stat_act, desc_req}, 32'h0);
        chk("R3 no data", {16'(fifo_lvl), bytes_left}, {16'h0, 16'd16});
        xfer_req = 1'b0;
    endtask

    task automatic t_run_stop;
        int e0 = n_eob, d0 = n_dreq;
        sink_rdy = 1'b0;
        xfer_req = 1'b1;
        cfg_write(32'h0018_0001);
        chk("R11 en before", {31'h0, stat_en}, 32'h0);
        @(negedge clk);
        chk("R11 en after", {31'h0, stat_en}, 32'h1);
        chk("R11 no beat yet", 32'(fifo_lvl), 32'h0);
        @(negedge clk);
        chk("R11 first beat", 32'(fifo_lvl), 32'h1);
        chk("R4 step", 32'(bytes_left), 32'd20);
        idle(8);
        chk("R12 full", 32'(fifo_lvl), DEPTH);
        chk("R12 stalled count", 32'(bytes_left), 32'd8);
        sink_rdy = 1'b1;
        for (int i = 0; i < 50 && stat_act; i++) @(negedge clk);
        chk("R4 eob once", 32'(n_eob - e0), 32'd1);
        chk("R4 run cleared", {31'h0, ctrl_word[0]}, 32'h0);
        chk("R5 frozen", {30'h0, stat_en, stat_act}, 32'h0);
        chk("R5 drained", {16'(fifo_lvl), bytes_left}, 32'h0);
        chk("R5 no fetch", 32'(n_dreq - d0), 32'h0);
        xfer_req = 1'b0;
    endtask

    task automatic t_load_now;
        int l0 = n_dld;
        cfg_write(32'h0008_0002);
        idle(3);
        chk("R6 waits for request", {31'h0, desc_req}, 32'h0);
        xfer_req = 1'b1;
        for (int i = 0; i < 10 && !desc_req; i++) @(negedge clk);
        chk("R6 fetch raised", {31'h0, desc_req}, 32'h1);
        chk("R6 no data", {16'(fifo_lvl), bytes_left}, {16'h0, 16'd8});
        xfer_req = 1'b0;
        give_desc(32'h000C_0000);
        chk("R6 word replaced", ctrl_word, 32'h000C_0000);
        chk("R6 length reloaded", 32'(bytes_left), 32'd12);
        chk("R6 one dld", 32'(n_dld - l0), 32'd1);
        @(negedge clk);
        chk("R6 frozen after", {30'h0, stat_act, desc_req}, 32'h0);
    endtask

    task automatic t_run_link;
        int e0 = n_eob, l0 = n_dld;
        sink_rdy = 1'b1;
        xfer_req = 1'b1;
        cfg_write(32'h0008_0003);
        for (int i = 0; i < 40 && !desc_req; i++) @(negedge clk);
        chk("R7 fetch after eob", {31'h0, desc_req}, 32'h1);
        chk("R7 en dropped", {31'h0, stat_en}, 32'h0);
        chk("R7 buffer done", {16'(fifo_lvl), bytes_left}, 32'h0);
        give_desc(32'h0004_0001);
        @(negedge clk);
        chk("R7 next buffer runs", {31'h0, stat_en}, 32'h1);
        for (int i = 0; i < 40 && stat_act; i++) @(negedge clk);
        chk("R7 two eob", 32'(n_eob - e0), 32'd2);
        chk("R7 one dld", 32'(n_dld - l0), 32'd1);
        chk("R7 final word", ctrl_word, 32'h0004_0000);
        xfer_req = 1'b0;
    endtask

    task automatic t_drain;
        int d0 = n_dreq;
        sink_rdy = 1'b0;
        xfer_req = 1'b1;
        cfg_write(32'h0028_0001);
        idle(10);
        chk("R12 full again", 32'(fifo_lvl), DEPTH);
        cfg_write(32'h1234_00FC);
        chk("R10 only cmd bits", ctrl_word, 32'h0028_0000);
        idle(8);
        chk("R8 en held", {31'h0, stat_en}, 32'h1);
        chk("R8 no new data", {16'(fifo_lvl), bytes_left}, {16'(DEPTH), 16'd24});
        sink_rdy = 1'b1;
        for (int i = 0; i < 20 && stat_en; i++) @(negedge clk);
        chk("R8 empty at drop", {16'(fifo_lvl), bytes_left}, {16'h0, 16'd24});
        chk("R8 frozen no fetch", {31'h0, stat_act}, 32'(n_dreq - d0));
        xfer_req = 1'b0;
    endtask

    task automatic t_skip;
        int l0 = n_dld;
        sink_rdy = 1'b0;
        xfer_req = 1'b1;
        cfg_write(32'h0028_0001);
        idle(10);
        cfg_write(32'h0000_0002);
        chk("R10 link taken", ctrl_word, 32'h0028_0002);
        idle(5);
        chk("R9 en while full", {31'h0, stat_en}, 32'h1);
        sink_rdy = 1'b1;
        for (int i = 0; i < 20 && !desc_req; i++) @(negedge clk);
        chk("R9 skip fetch", {31'h0, desc_req}, 32'h1);
        chk("R9 rest skipped", {16'(fifo_lvl), bytes_left}, {16'h0, 16'd24});
        give_desc(32'h0014_0000);
        chk("R9 next word", ctrl_word, 32'h0014_0000);
        chk("R9 dld", 32'(n_dld - l0), 32'd1);
        chk("R9 frozen", {31'h0, stat_act}, 32'h0);
        xfer_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stop_mode();
        t_run_stop();
        t_load_now();
        t_run_link();
        t_drain();
        t_skip();
        idle(4);
        summary();
    end
endmodule